// File: doc/BRIEF.md
# Warm Reset Control Unit

This block watches four warm reset requests: a system reset coming from the debug port, a software reset request from the CPU, a CPU lockup indication and a watchdog timeout. A rising edge on a request that is allowed through produces a one-cycle pulse on one of two outputs. The warm reset output fires by default. The emulated pin reset output fires instead when software has set the enable bit, so that the rest of the chip can run a full power-up sequence.

While the debug-port reset input is high, the other three requests are blocked. The watchdog and lockup events are also recorded in two sticky status flags. Software reads them through one 32-bit register on a plain bus with read and write strobes. Any read returns the flags and then clears both.

The enable bit and the flags survive the block's own warm or pin pulses. Only the block's power-on reset input clears them.

Top module: `warm_reset_ctrl`

## Requirements
- R1: After the power-on reset (`rst_n` low at a clock edge), the register reads 0x00000000 and both reset outputs are low.
- R2: A rising edge on `wdt_timeout_i` sets the watchdog flag at register bit 0. The flag stays set until a register read clears it.
- R3: A rising edge on `lockup_i` sets the lockup flag at register bit 1. The flag stays set until a register read clears it.
- R4: A read returns the register contents as they were before the read, in the same cycle as `bus_rd_i`. After that clock edge, both flags read 0.
- R5: If a watchdog or lockup rising edge arrives in the same cycle as a read, the read returns the old value and the flag set by the new event reads 1 afterwards.
- R6: Register bit 2 is the enable bit. It is written from `bus_wdata_i[2]` and reads back the value last written. Bits 31..3 read 0. Writes to bits 31..3 and to bits 1..0 have no effect.
- R7: With the enable bit at 0, a qualifying rising edge on any request raises `warm_rst_o` for exactly the next cycle, and `pin_rst_o` stays low.
- R8: With the enable bit at 1, a qualifying rising edge on any request raises `pin_rst_o` for exactly the next cycle, and `warm_rst_o` stays low.
- R9: While `dbg_sysrst_i` is high, rising edges on `cpu_rstreq_i`, `lockup_i` and `wdt_timeout_i` produce no output pulse. They still set their status flags. A rising edge of `dbg_sysrst_i` itself always qualifies.
- R10: The two outputs are never high together. Each pulse lasts one cycle, even when the request stays high.
- R11: The enable value held in the register before a clock edge selects the output for a request detected at that edge. A write at that same edge does not affect the choice.
- R12: Output pulses do not alter the enable bit or the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| dbg_sysrst_i | input | 1 | System reset request from the debug port (level) |
| cpu_rstreq_i | input | 1 | Software reset request from the CPU (level) |
| lockup_i | input | 1 | CPU lockup indication (level) |
| wdt_timeout_i | input | 1 | Watchdog timeout indication (level) |
| bus_rd_i | input | 1 | Register read strobe |
| bus_wr_i | input | 1 | Register write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data (combinational view of the register) |
| warm_rst_o | output | 1 | One-cycle warm reset pulse |
| pin_rst_o | output | 1 | One-cycle emulated pin reset pulse |

## Verification
The assertions assume that the request inputs are synchronous to `clk` and that a request is a level held for at least one clock edge. Only a low-to-high change counts as a new request.

The stimulus drives every input one time unit after a rising edge. Each request is raised for two edges and then dropped with an idle cycle before the next one, so every edge is seen as a clean single transition. The strobes follow the same discipline: each one is asserted for exactly one edge.

The sweep covers each request under both enable values, with the debug reset idle and then held high. Collisions are driven on purpose so that the same-edge orderings get exercised: a read with an event, and a write with a request.

// File: rtl/wrc_pkg.sv
// Package: shared constants for the warm reset control unit.
// Assumes: request vector index order below is used by every module.
package wrc_pkg;
    localparam int DATA_W   = 32;
    localparam int NSRC     = 4;
    // request indices
    localparam int SRC_DBG  = 0;
    localparam int SRC_CPU  = 1;
    localparam int SRC_LOCK = 2;
    localparam int SRC_WDT  = 3;
    // register bit positions
    localparam int BIT_WDT  = 0;
    localparam int BIT_LOCK = 1;
    localparam int BIT_EN   = 2;
    localparam int USED_W   = 3;
endpackage

// File: rtl/wrc_source_gate.sv
// Module: wrc_source_gate
// Detects a rising edge on each reset request and applies debug masking.
// Assumes: requests are synchronous to clk; index SRC_DBG is the debug reset.
module wrc_source_gate
    import wrc_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_i,
    output logic [N-1:0] rise_o,
    output logic         req_o
);
    logic [N-1:0] src_q;
    logic [N-1:0] pass;

    // Remember last cycle's request levels.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src_i;
    end

    // Per-request edge detection and masking.
    generate
        for (genvar i = 0; i < N; i++) begin : g_src
            assign rise_o[i] = src_i[i] & ~src_q[i];
            if (i == SRC_DBG) begin : g_dbg
                assign pass[i] = rise_o[i];
            end else begin : g_other
                assign pass[i] = rise_o[i] & ~src_i[SRC_DBG];
            end
        end
    endgenerate

    // Any surviving edge is a qualified request.
    always_comb begin
        req_o = |pass;
    end

    AST_DBG_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i[SRC_DBG] && !rise_o[SRC_DBG]) |-> !req_o); // R9
endmodule

// File: rtl/wrc_status_reg.sv
// Module: wrc_status_reg
// Holds the enable bit and the sticky watchdog/lockup flags.
// Assumes: a read strobe clears both flags at the edge ending the read cycle.
module wrc_status_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wdt_ev_i,
    input  logic lock_ev_i,
    input  logic rd_clr_i,
    input  logic wr_i,
    input  logic wr_en_bit_i,
    output logic wdt_flag_o,
    output logic lock_flag_o,
    output logic enable_o
);
    // Sticky flags: a new event wins over a read clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdt_flag_o  <= 1'b0;
            lock_flag_o <= 1'b0;
        end else begin
            wdt_flag_o  <= wdt_ev_i  | (wdt_flag_o  & ~rd_clr_i);
            lock_flag_o <= lock_ev_i | (lock_flag_o & ~rd_clr_i);
        end
    end

    // Enable bit: software writable, cleared only by power-on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    enable_o <= 1'b0;
        else if (wr_i) enable_o <= wr_en_bit_i;
    end

    AST_WDT_STICKY:  assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_flag_o && !rd_clr_i) |=> wdt_flag_o); // R2
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_flag_o && !rd_clr_i) |=> lock_flag_o); // R3
    AST_RD_CLEARS:   assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && !wdt_ev_i && !lock_ev_i) |=> (!wdt_flag_o && !lock_flag_o)); // R4
    AST_EV_WINS:     assert property (@(posedge clk) disable iff (!rst_n)
        wdt_ev_i |=> wdt_flag_o); // R5
endmodule

// File: rtl/wrc_pulse_gen.sv
// Module: wrc_pulse_gen
// Turns a qualified request into one registered pulse on one of two outputs.
// Assumes: req_i is high for a single cycle per request (edge based).
module wrc_pulse_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic enable_i,
    output logic warm_o,
    output logic pin_o
);
    // Steer the request by the enable value held this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm_o <= 1'b0;
            pin_o  <= 1'b0;
        end else begin
            warm_o <= req_i & ~enable_i;
            pin_o  <= req_i &  enable_i;
        end
    end

    AST_OUT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(warm_o && pin_o)); // R10
    AST_WARM_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        warm_o |=> !warm_o); // R10
    AST_PIN_ONE:  assert property (@(posedge clk) disable iff (!rst_n)
        pin_o |=> !pin_o); // R10
endmodule

// File: rtl/warm_reset_ctrl.sv
// Module: warm_reset_ctrl (top)
// Collects four warm reset requests, emits a warm or emulated pin reset
// pulse, and exposes enable and sticky status through one register.
// Assumes: synchronous requests, one-cycle bus strobes.
module warm_reset_ctrl
    import wrc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_sysrst_i,
    input  logic              cpu_rstreq_i,
    input  logic              lockup_i,
    input  logic              wdt_timeout_i,
    input  logic              bus_rd_i,
    input  logic              bus_wr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              warm_rst_o,
    output logic              pin_rst_o
);
    logic [NSRC-1:0] src_vec;
    logic [NSRC-1:0] rise;
    logic            req;
    logic            wdt_flag;
    logic            lock_flag;
    logic            enable;
    logic            unused_wdata;

    assign src_vec[SRC_DBG]  = dbg_sysrst_i;
    assign src_vec[SRC_CPU]  = cpu_rstreq_i;
    assign src_vec[SRC_LOCK] = lockup_i;
    assign src_vec[SRC_WDT]  = wdt_timeout_i;
    assign unused_wdata = ^{bus_wdata_i[DATA_W-1:USED_W], bus_wdata_i[BIT_LOCK:BIT_WDT]};

    wrc_source_gate #(.N(NSRC)) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_vec),
        .rise_o (rise),
        .req_o  (req)
    );

    wrc_status_reg u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .wdt_ev_i    (rise[SRC_WDT]),
        .lock_ev_i   (rise[SRC_LOCK]),
        .rd_clr_i    (bus_rd_i),
        .wr_i        (bus_wr_i),
        .wr_en_bit_i (bus_wdata_i[BIT_EN]),
        .wdt_flag_o  (wdt_flag),
        .lock_flag_o (lock_flag),
        .enable_o    (enable)
    );

    wrc_pulse_gen u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req),
        .enable_i (enable),
        .warm_o   (warm_rst_o),
        .pin_o    (pin_rst_o)
    );

    // Assemble the read view; reserved bits are zero.
    always_comb begin
        bus_rdata_o           = '0;
        bus_rdata_o[BIT_WDT]  = wdt_flag;
        bus_rdata_o[BIT_LOCK] = lock_flag;
        bus_rdata_o[BIT_EN]   = enable;
    end

    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr_i) |=> $stable(bus_rdata_o[BIT_EN])); // R12
    AST_PIN_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        pin_rst_o |-> $past(bus_rdata_o[BIT_EN])); // R11
endmodule

// File: tb/warm_reset_ctrl_test.sv
module warm_reset_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbg = 1'b0, cpu = 1'b0, lock = 1'b0, wdt = 1'b0;
    logic        rd = 1'b0, wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        warm, pin;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    warm_reset_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .dbg_sysrst_i(dbg), .cpu_rstreq_i(cpu), .lockup_i(lock), .wdt_timeout_i(wdt),
        .bus_rd_i(rd), .bus_wr_i(wr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .warm_rst_o(warm), .pin_rst_o(pin)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_read(output logic [31:0] val);
        rd = 1'b1;
        #1 val = rdata;
        step();
        rd = 1'b0;
    endtask

    task automatic do_write(input logic [31:0] val);
        wr = 1'b1; wdata = val;
        step();
        wr = 1'b0; wdata = '0;
    endtask

    task automatic set_src(input int s, input logic v);
        case (s)
            0: dbg = v;
            1: cpu = v;
            2: lock = v;
            default: wdt = v;
        endcase
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] v;
        logic [31:0] exp;
        step(); step();
        // R1 reset state
        chk("R1 rdata", rdata, 32'h0);
        chk("R1 outs", {30'b0, warm, pin}, 32'h0);
        rst_n = 1'b1;
        step();
        chk("R1 idle", {30'b0, warm, pin}, 32'h0);

        // R6 reserved and status bits ignore writes
        do_write(32'hFFFF_FFFF);
        chk("R6 write all ones", rdata, 32'h4);
        do_write(32'hFFFF_FFFB);
        chk("R6 write en=0", rdata, 32'h0);

        // Sweep: request x enable x debug-held
        for (int held = 0; held < 2; held++) begin
            for (int en = 0; en < 2; en++) begin
                for (int s = 0; s < 4; s++) begin
                    if (held == 1 && s == 0) continue;
                    do_write(en ? 32'h4 : 32'h0);
                    do_read(v);
                    if (held == 1) begin
                        dbg = 1'b1;
                        step();
                        chk(en ? "R8 dbg pin" : "R7 dbg warm", {30'b0, warm, pin},
                            en ? 32'h1 : 32'h2);
                        step();
                    end
                    set_src(s, 1'b1);
                    step();
                    exp = (held == 1) ? 32'h0 : (en ? 32'h1 : 32'h2);
                    chk(held ? "R9 masked" : (en ? "R8 pin pulse" : "R7 warm pulse"),
                        {30'b0, warm, pin}, exp);
                    step();
                    chk("R10 single pulse", {30'b0, warm, pin}, 32'h0);
                    set_src(s, 1'b0);
                    dbg = 1'b0;
                    step();
                    exp = (s == 3 ? 32'h1 : 32'h0) | (s == 2 ? 32'h2 : 32'h0) | (en ? 32'h4 : 32'h0);
                    do_read(v);
                    chk("R2 R3 R9 R12 status after pulse", v, exp);
                    chk("R4 cleared", rdata, en ? 32'h4 : 32'h0);
                end
            end
        end

        // R5 event coincides with read
        do_write(32'h0);
        wdt = 1'b1; lock = 1'b1;
        do_read(v);
        chk("R5 old value", v, 32'h0);
        chk("R5 event wins", rdata, 32'h3);
        step();
        wdt = 1'b0; lock = 1'b0;
        step();
        chk("R2 R3 held", rdata, 32'h3);
        do_write(32'h0);
        chk("R6 write ignores flags", rdata, 32'h3);
        do_read(v);
        chk("R4 read data", v, 32'h3);
        chk("R4 both cleared", rdata, 32'h0);

        // R11 write on the same edge as a request: old enable chooses
        cpu = 1'b1;
        do_write(32'h4);
        chk("R11 old enable -> warm", {30'b0, warm, pin}, 32'h2);
        cpu = 1'b0;
        step();
        dbg = 1'b1;
        do_write(32'h0);
        chk("R11 old enable -> pin", {30'b0, warm, pin}, 32'h1);
        dbg = 1'b0;
        step();
        chk("R12 enable kept", rdata, 32'h0);

        summary();
    end
endmodule